// File: doc/BRIEF.md
# Modified Immediate Constant Expander

This block turns the 12-bit packed immediate field of a data-processing instruction into the 32-bit operand that the ALU consumes. It also works out the carry that the instruction should see. The field encodes a constant in one of two ways.

The first way places one byte in a fixed replication pattern across the word. The second way takes an 8-bit value whose top bit is always set and rotates it to any position in the word.

Alongside the constant, the block decides whether a flag-setting logical instruction should overwrite the carry flag. When it should, the new carry is bit 31 of the constant. A separate status output marks replicated encodings that ask for a repeated byte but supply a zero byte. A parameter chooses between a purely combinational result and a result registered by one clock.

Top module: `mimm_expand`

## Requirements
- R1: When field[11:10] is 00 and field[9:8] is 00, the constant is the byte field[7:0] zero-extended, i.e. 0x000000XY with XY = field[7:0].
- R2: When field[11:10] is 00 and field[9:8] is 01, the constant is 0x00XY00XY, with XY = field[7:0] in bits [23:16] and [7:0].
- R3: When field[11:10] is 00 and field[9:8] is 10, the constant is 0xXY00XY00, with XY = field[7:0] in bits [31:24] and [15:8].
- R4: When field[11:10] is 00 and field[9:8] is 11, the constant is 0xXYXYXYXY, with XY = field[7:0] in every byte lane.
- R5: When field[11:10] is not 00, the constant is the 8-bit value {1, field[6:0]}, zero-extended to 32 bits and rotated right by field[11:7] (8 to 31). Such a constant is always greater than 255.
- R6: When the set-flags input is 1 and field[11:10] is not 00, the carry-update output is 1 and the carry output equals bit 31 of the constant.
- R7: In every other case, the carry-update output is 0 and the carry output equals the carry input.
- R8: The unpredictable-encoding output is 1 exactly when field[11:10] is 00, field[9:8] is not 00, and field[7:0] is zero. Otherwise it is 0.
- R9: With REG_OUT = 1 (the default), every output shows the result for the inputs of the previous clock. While the synchronous active-high reset is asserted, every output is cleared to 0 at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| imm_field | input | 12 | Packed immediate field |
| carry_in | input | 1 | Current carry flag |
| set_flags | input | 1 | Instruction is a flag-setting logical operation |
| imm_value | output | 32 | Expanded 32-bit constant |
| carry_out | output | 1 | Carry the instruction should see |
| carry_we | output | 1 | Carry flag should be written |
| enc_unpred | output | 1 | Replicated pattern with a zero byte |

## Verification
Two cases are hard to reach from the ports.

The first is a rotation that leaves bit 31 of the constant clear while a flag-setting instruction is active. In that case the carry output must drop even though the carry input is high.

The second is the handful of replicated encodings with a zero byte, which set the status output.

Both cases are reached by sweeping all 4096 field values under each of the four combinations of set-flags and carry input. A queue-based model checks every output on the clock after the inputs are applied.

// File: rtl/mimm_pkg.sv
package mimm_pkg;
    localparam int IMM_W  = 12;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int ROT_W  = 5;
    localparam int LANES  = WORD_W / BYTE_W;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              carry;
        logic              carry_upd;
        logic              unpred;
    } mimm_res_t;

    // Replication pattern select values, taken from field[9:8]
    localparam logic [1:0] PAT_SINGLE = 2'b00;
    localparam logic [1:0] PAT_EVEN   = 2'b01;
    localparam logic [1:0] PAT_ODD    = 2'b10;
    localparam logic [1:0] PAT_ALL    = 2'b11;
endpackage

// File: rtl/mimm_replicate.sv
module mimm_replicate
    import mimm_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int NL = LANES
) (
    input  logic [BW-1:0]    byte_in,
    input  logic [1:0]       pat_sel,
    output logic [BW*NL-1:0] value,
    output logic             zero_rep
);
    logic [NL-1:0] lane_en;

    generate
        for (genvar i = 0; i < NL; i++) begin : g_lane
            always_comb begin
                case (pat_sel)
                    PAT_SINGLE: lane_en[i] = (i == 0);
                    PAT_EVEN:   lane_en[i] = (i % 2 == 0);
                    PAT_ODD:    lane_en[i] = (i % 2 == 1);
                    default:    lane_en[i] = 1'b1;
                endcase
            end
            assign value[i*BW +: BW] = lane_en[i] ? byte_in : '0;
        end
    endgenerate

    // A repeating pattern that carries no nonzero byte is flagged
    assign zero_rep = (pat_sel != PAT_SINGLE) && (byte_in == '0);
endmodule

// File: rtl/mimm_rotate.sv
module mimm_rotate
    import mimm_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int WW = WORD_W,
    parameter int RW = ROT_W
) (
    input  logic [BW-2:0] low_bits,
    input  logic [RW-1:0] amount,
    output logic [WW-1:0] value
);
    localparam int DW = 2 * WW;

    logic [WW-1:0] base;
    logic [DW-1:0] doubled;
    logic [DW-1:0] shifted;

    assign base    = {{(WW-BW){1'b0}}, 1'b1, low_bits};
    assign doubled = {base, base};
    assign shifted = doubled >> amount;
    assign value   = shifted[WW-1:0];
endmodule

// File: rtl/mimm_carry.sv
module mimm_carry (
    input  logic rot_form,
    input  logic set_flags,
    input  logic msb,
    input  logic cin,
    output logic cout,
    output logic upd
);
    always_comb begin
        upd  = rot_form & set_flags;
        cout = upd ? msb : cin;
    end
endmodule

// File: rtl/mimm_expand.sv
module mimm_expand
    import mimm_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IMM_W-1:0]  imm_field,
    input  logic              carry_in,
    input  logic              set_flags,
    output logic [WORD_W-1:0] imm_value,
    output logic              carry_out,
    output logic              carry_we,
    output logic              enc_unpred
);
    mimm_res_t res_d;
    mimm_res_t res_q;

    logic              rot_form;
    logic [WORD_W-1:0] rep_val;
    logic [WORD_W-1:0] rot_val;
    logic              rep_zero;
    logic              c_out;
    logic              c_upd;
    logic [WORD_W-1:0] sel_val;

    assign rot_form = |imm_field[IMM_W-1:IMM_W-2];
    assign sel_val  = rot_form ? rot_val : rep_val;

    mimm_replicate u_rep (
        .byte_in  (imm_field[BYTE_W-1:0]),
        .pat_sel  (imm_field[BYTE_W+1:BYTE_W]),
        .value    (rep_val),
        .zero_rep (rep_zero)
    );

    mimm_rotate u_rot (
        .low_bits (imm_field[BYTE_W-2:0]),
        .amount   (imm_field[IMM_W-1:IMM_W-ROT_W]),
        .value    (rot_val)
    );

    mimm_carry u_car (
        .rot_form  (rot_form),
        .set_flags (set_flags),
        .msb       (sel_val[WORD_W-1]),
        .cin       (carry_in),
        .cout      (c_out),
        .upd       (c_upd)
    );

    always_comb begin
        res_d           = '0;
        res_d.value     = sel_val;
        res_d.carry     = c_out;
        res_d.carry_upd = c_upd;
        res_d.unpred    = ~rot_form & rep_zero;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) res_q <= '0;
                else     res_q <= res_d;
            end

            assert_reg_delay_R9: assert property (@(posedge clk) disable iff (rst)
                !rst |=> (res_q == $past(res_d)));
        end else begin : g_comb
            assign res_q = res_d;
        end
    endgenerate

    assign imm_value  = res_q.value;
    assign carry_out  = res_q.carry;
    assign carry_we   = res_q.carry_upd;
    assign enc_unpred = res_q.unpred;

    assert_single_R1: assert property (@(posedge clk) disable iff (rst)
        (imm_field[11:8] == 4'b0000) |-> (res_d.value == {24'b0, imm_field[7:0]}));

    assert_all_lanes_R4: assert property (@(posedge clk) disable iff (rst)
        (imm_field[11:8] == 4'b0011) |->
        (res_d.value[31:24] == imm_field[7:0] && res_d.value[15:8] == imm_field[7:0]));

    assert_rot_shape_R5: assert property (@(posedge clk) disable iff (rst)
        rot_form |-> (res_d.value > 32'd255 &&
                      $countones(res_d.value) == $countones(imm_field[6:0]) + 1));

    assert_carry_we_R6: assert property (@(posedge clk) disable iff (rst)
        res_d.carry_upd |-> (set_flags && rot_form && res_d.carry == res_d.value[31]));

    assert_carry_keep_R7: assert property (@(posedge clk) disable iff (rst)
        !res_d.carry_upd |-> (res_d.carry == carry_in));

    assert_unpred_R8: assert property (@(posedge clk) disable iff (rst)
        res_d.unpred |-> (imm_field[11:10] == 2'b00 && imm_field[9:8] != 2'b00 &&
                          imm_field[7:0] == 8'h00));
endmodule

// File: tb/sim_mimm_expand.sv
`timescale 1ns/1ps
module sim_mimm_expand;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] imm_field = '0;
    logic        carry_in = 1'b0;
    logic        set_flags = 1'b0;
    logic [31:0] imm_value;
    logic        carry_out;
    logic        carry_we;
    logic        enc_unpred;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        int          f;
        logic [31:0] v;
        logic        c;
        logic        w;
        logic        u;
    } exp_t;

    exp_t exq[$];

    always #5 clk = ~clk;

    mimm_expand u0 (
        .clk        (clk),
        .rst        (rst),
        .imm_field  (imm_field),
        .carry_in   (carry_in),
        .set_flags  (set_flags),
        .imm_value  (imm_value),
        .carry_out  (carry_out),
        .carry_we   (carry_we),
        .enc_unpred (enc_unpred)
    );

    function automatic string val_tag(int f);
        if (f >= 1024) return "R5";
        case ((f >> 8) & 3)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic exp_t model(int f, logic cin, logic sf);
        exp_t e;
        logic [31:0] xy;
        logic [31:0] v;
        int rot;
        e.f = f;
        xy = f & 255;
        if (f < 1024) begin
            case ((f >> 8) & 3)
                0: v = xy;
                1: v = xy * 32'h0001_0001;
                2: v = xy * 32'h0100_0100;
                default: v = xy * 32'h0101_0101;
            endcase
            e.u = (((f >> 8) & 3) != 0) && (xy == 0);
            e.w = 1'b0;
            e.c = cin;
        end else begin
            v = 128 + (f & 127);
            rot = f >> 7;
            for (int k = 0; k < rot; k++) v = {v[0], v[31:1]};
            e.u = 1'b0;
            e.w = sf;
            e.c = sf ? v[31] : cin;
        end
        e.v = v;
        return e;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv, int f);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s field=%03h actual=%08h expected=%08h", tag, f, act, expv);
        end
    endtask

    task automatic compare_head();
        exp_t e;
        e = exq.pop_front();
        chk(val_tag(e.f), imm_value, e.v, e.f);
        chk(e.w ? "R6" : "R7", {31'b0, carry_out}, {31'b0, e.c}, e.f);
        chk(e.w ? "R6" : "R7", {31'b0, carry_we}, {31'b0, e.w}, e.f);
        chk("R8", {31'b0, enc_unpred}, {31'b0, e.u}, e.f);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        imm_field = 12'hFFF;
        carry_in = 1'b1;
        set_flags = 1'b1;
        repeat (3) @(negedge clk);
        // R9: reset clears all outputs
        chk("R9", imm_value, 32'h0, 0);
        chk("R9", {29'b0, carry_out, carry_we, enc_unpred}, 32'h0, 0);
        rst = 1'b0;
        for (int mode = 0; mode < 4; mode++) begin
            for (int f = 0; f < 4096; f++) begin
                if (exq.size() > 0) compare_head();
                imm_field = f[11:0];
                carry_in  = mode[0];
                set_flags = mode[1];
                exq.push_back(model(f, mode[0], mode[1]));
                @(negedge clk);
            end
        end
        compare_head();
        // R9: reset in mid-run clears outputs on the next edge
        imm_field = 12'hEFF;
        set_flags = 1'b1;
        carry_in  = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        chk("R9", imm_value, 32'h0, 12'hEFF);
        chk("R9", {29'b0, carry_out, carry_we, enc_unpred}, 32'h0, 12'hEFF);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule